// File: doc/BRIEF.md
# Exception stack frame sequencer

This block builds and tears down processor exception frames on a memory stack, one transfer at a time, through a single word/long memory port with a request/ready handshake. When an exception request arrives, it captures the vector number, status word, stack pointer, current PC, fault address and vector base. It then computes the supervisor status and pushes a frame whose layout depends on the exception kind. Last, it reads the handler address from the vector table. The caller takes the new status, stack pointer and PC from the result outputs when `done` pulses.

A return request walks the opposite way. It reads the saved status and return PC, then reads the format word, and moves the stack pointer past whatever extra words that format carries. A throwaway frame makes the block restart the unwind one frame higher. An unknown format code reports an error and leaves the result outputs untouched. A second fault that arrives while the long fault frame is being written freezes the block in a halted state that only reset clears.

Top module: `exc_frame_seq`

## Requirements
- R1: On entry the resulting status has bit 13 (supervisor) set and bit 15 (trace) cleared, with all other bits kept from `sr_in`. For a hardware interrupt (`exc_hw`=1), bits 10:8 are loaded with `exc_ipl`. The result appears on `sr_out` when `done` pulses.
- R2: Bit 0 of `sp_in` is cleared before the first push, so every write goes to an even address.
- R3: A frame lies upward from its lowest address F in this order. The 16-bit old status is at F. The 32-bit return address is at F+2. At F+6 is the 16-bit format word, equal to format×4096 + vector×4. Any extra long words follow from F+8. All data is big-endian.
- R4: `exc_kind` selects the software frame. The codes are:
  - 0: format 0, with no extra words.
  - 1: format 2, with one extra long holding `fault_addr`.
  - 2: format 4, with `fault_addr` at F+8 and `pc_in` at F+12.
  - 3: format 7, with 13 extra longs. `fault_addr` is at F+8 and zeros fill the rest.

  A hardware interrupt always uses format 0.
- R5: For a software exception with `exc_trap`=1, the saved return address is `pc_in`+2. Otherwise it is `pc_in`.
- R6: A hardware interrupt whose `sr_in` has bit 12 (master) set pushes a format-0 frame that holds `sr_in`. It then pushes a format-1 frame just below it that holds the R1 status with bit 12 still set. The final `sr_out` has bit 12 cleared.
- R7: After the pushes, `pc_out` takes the long read from `vbr`+vector×4, and `sp_out` takes the lowest frame address.
- R8: A return reads the status at SP, the PC at SP+2 and the format word at SP+6. The stack pointer then advances by a total that depends on the format: 8 for format 0, 12 for formats 2 and 3, 16 for format 4, and 60 for format 7. Format 1 restarts the unwind at SP+8.
- R9: A format code outside {0,1,2,3,4,7} on return pulses `fmt_err` together with `done`, and `sr_out`, `sp_out` and `pc_out` keep their previous values.
- R10: `fault_in` during the pushes of a format-7 frame drives `halt` high. The memory port and `busy` then stay idle until reset. The same input during any other frame has no effect.
- R11: `mem_req` stays high with stable address, size, direction and write data until `mem_rdy` is sampled high. `mem_size` is 1 for a long transfer and 0 for a word transfer, and a word uses bits 15:0 of the data.
- R12: `busy` rises the cycle after a request is accepted and falls when `done` pulses for one cycle. `exc_req` wins over `rte_req` when both are high, and requests are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| exc_req | input | 1 | Start exception entry |
| rte_req | input | 1 | Start return from exception |
| exc_kind | input | 2 | Software frame kind (R4) |
| exc_hw | input | 1 | Entry is a hardware interrupt |
| exc_ipl | input | 3 | Pending interrupt level |
| exc_trap | input | 1 | Entry is a trap instruction |
| exc_vec | input | VW | Vector number |
| sr_in | input | 16 | Current status word |
| sp_in | input | AW | Current stack pointer |
| pc_in | input | AW | Current PC |
| fault_addr | input | AW | Faulting address for extra words |
| vbr | input | AW | Vector table base |
| fault_in | input | 1 | Access fault during frame build |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = long, 0 = word |
| mem_addr | output | AW | Transfer address |
| mem_wdata | output | AW | Write data |
| mem_rdata | input | AW | Read data |
| mem_rdy | input | 1 | Transfer completes at this edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | Unknown format on return |
| halt | output | 1 | Double fault, frozen |
| sr_out | output | 16 | Resulting status word |
| sp_out | output | AW | Resulting stack pointer |
| pc_out | output | AW | Resulting PC |

## Verification
On every cycle, the bound checker watches the port-level rules. These cover handshake stability, even push addresses, `done` lasting one cycle, the silence and permanence of the halted state, and result outputs that move only with `done` and never with a format error. Frame contents are a matter of data, so only the bench scenarios can show them: the word order in memory, the format words, the extra longs per kind, the two-frame master case, trap return addresses, and how far each format moves the stack on return. These are checked against bench-computed expectations over random entries followed by round-trip returns.

// File: rtl/exc_frame_seq.sv
module exc_frame_seq #(
  parameter int AW = 32,
  parameter int VW = 8,
  parameter int F7_LONGS = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_req,
  input  logic          rte_req,
  input  logic [1:0]    exc_kind,
  input  logic          exc_hw,
  input  logic [2:0]    exc_ipl,
  input  logic          exc_trap,
  input  logic [VW-1:0] exc_vec,
  input  logic [15:0]   sr_in,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] fault_addr,
  input  logic [AW-1:0] vbr,
  input  logic          fault_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_rdy,
  output logic          busy,
  output logic          done,
  output logic          fmt_err,
  output logic          halt,
  output logic [15:0]   sr_out,
  output logic [AW-1:0] sp_out,
  output logic [AW-1:0] pc_out
);
  localparam int CW = $clog2(F7_LONGS + 1);
  localparam int F7_SKIP = F7_LONGS * 4;
  localparam int B_T = 15;
  localparam int B_S = 13;
  localparam int B_M = 12;

  typedef enum logic [3:0] {
    S_IDLE, S_XTRA, S_FMTW, S_RET, S_SRW, S_VEC, S_PSR, S_PPC, S_PFW, S_HALT
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [3:0]    fmt_r;
  logic [VW-1:0] vec_r;
  logic [AW-1:0] sp_r, ret_r, pc_r, fa_r, vbr_r, pc_pop;
  logic [15:0]   sr_old, sr_new, sr_pop;
  logic          nest_r;

  logic          is_push, xfer;
  logic [AW-1:0] step;
  logic [15:0]   fw;
  logic [15:0]   sr_ent;
  logic [3:0]    pfmt;
  logic          pknown;
  logic [AW-1:0] pskip;

  assign is_push  = (st == S_XTRA) || (st == S_FMTW) || (st == S_RET) || (st == S_SRW);
  assign mem_req  = is_push || (st == S_VEC) || (st == S_PSR) || (st == S_PPC) || (st == S_PFW);
  assign mem_we   = is_push;
  assign mem_size = (st == S_XTRA) || (st == S_RET) || (st == S_VEC) || (st == S_PPC);
  assign step     = mem_size ? AW'(4) : AW'(2);
  assign xfer     = mem_req && mem_rdy;
  assign busy     = (st != S_IDLE) && (st != S_HALT);
  assign halt     = (st == S_HALT);
  assign fw       = {fmt_r, 12'h000} | (16'(vec_r) << 2);
  assign pfmt     = mem_rdata[15:12];

  assign mem_addr = is_push ? sp_r - step
                  : (st == S_VEC) ? vbr_r + (AW'(vec_r) << 2)
                  : sp_r;

  always_comb begin
    case (st)
      S_XTRA:  mem_wdata = (cnt == CW'(1)) ? fa_r : ((fmt_r == 4'd4) ? pc_r : '0);
      S_FMTW:  mem_wdata = AW'(fw);
      S_RET:   mem_wdata = ret_r;
      S_SRW:   mem_wdata = AW'(sr_old);
      default: mem_wdata = '0;
    endcase
  end

  always_comb begin
    sr_ent = (sr_in | 16'(1 << B_S)) & ~16'(1 << B_T);
    if (exc_hw) sr_ent[10:8] = exc_ipl;
  end

  always_comb begin
    pknown = 1'b1;
    pskip  = '0;
    case (pfmt)
      4'd0:       pskip = '0;
      4'd2, 4'd3: pskip = AW'(4);
      4'd4:       pskip = AW'(8);
      4'd7:       pskip = AW'(F7_SKIP);
      default:    pknown = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      fmt_r   <= '0;
      vec_r   <= '0;
      sp_r    <= '0;
      ret_r   <= '0;
      pc_r    <= '0;
      fa_r    <= '0;
      vbr_r   <= '0;
      pc_pop  <= '0;
      sr_old  <= '0;
      sr_new  <= '0;
      sr_pop  <= '0;
      nest_r  <= 1'b0;
      done    <= 1'b0;
      fmt_err <= 1'b0;
      sr_out  <= '0;
      sp_out  <= '0;
      pc_out  <= '0;
    end else begin
      done    <= 1'b0;
      fmt_err <= 1'b0;
      case (st)
        S_IDLE: begin
          if (exc_req) begin
            sr_old <= sr_in;
            sr_new <= sr_ent;
            sp_r   <= sp_in & ~AW'(1);
            pc_r   <= pc_in;
            fa_r   <= fault_addr;
            vbr_r  <= vbr;
            vec_r  <= exc_vec;
            ret_r  <= (exc_trap && !exc_hw) ? pc_in + AW'(2) : pc_in;
            nest_r <= exc_hw && sr_in[B_M];
            if (exc_hw || exc_kind == 2'd0) begin
              fmt_r <= 4'd0;
              cnt   <= '0;
              st    <= S_FMTW;
            end else begin
              st <= S_XTRA;
              case (exc_kind)
                2'd1:    begin fmt_r <= 4'd2; cnt <= CW'(1); end
                2'd2:    begin fmt_r <= 4'd4; cnt <= CW'(2); end
                default: begin fmt_r <= 4'd7; cnt <= CW'(F7_LONGS); end
              endcase
            end
          end else if (rte_req) begin
            sp_r <= sp_in;
            st   <= S_PSR;
          end
        end
        S_XTRA: if (xfer) begin
          sp_r <= sp_r - AW'(4);
          cnt  <= cnt - CW'(1);
          if (cnt == CW'(1)) st <= S_FMTW;
        end
        S_FMTW: if (xfer) begin
          sp_r <= sp_r - AW'(2);
          st   <= S_RET;
        end
        S_RET: if (xfer) begin
          sp_r <= sp_r - AW'(4);
          st   <= S_SRW;
        end
        S_SRW: if (xfer) begin
          if (nest_r) begin
            nest_r      <= 1'b0;
            sr_old      <= sr_new;
            sr_new[B_M] <= 1'b0;
            fmt_r       <= 4'd1;
            sp_r        <= (sp_r - AW'(2)) & ~AW'(1);
            st          <= S_FMTW;
          end else begin
            sp_r <= sp_r - AW'(2);
            st   <= S_VEC;
          end
        end
        S_VEC: if (xfer) begin
          pc_out <= mem_rdata;
          sr_out <= sr_new;
          sp_out <= sp_r;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        S_PSR: if (xfer) begin
          sr_pop <= mem_rdata[15:0];
          sp_r   <= sp_r + AW'(2);
          st     <= S_PPC;
        end
        S_PPC: if (xfer) begin
          pc_pop <= mem_rdata;
          sp_r   <= sp_r + AW'(4);
          st     <= S_PFW;
        end
        S_PFW: if (xfer) begin
          if (pfmt == 4'd1) begin
            sp_r <= sp_r + AW'(2);
            st   <= S_PSR;
          end else if (pknown) begin
            sr_out <= sr_pop;
            pc_out <= pc_pop;
            sp_out <= sp_r + AW'(2) + pskip;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else begin
            fmt_err <= 1'b1;
            done    <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: ;
      endcase
      if (fault_in && is_push && fmt_r == 4'd7) st <= S_HALT;
    end
  end
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fault_in,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_size,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_rdy,
  input logic          busy,
  input logic          done,
  input logic          fmt_err,
  input logic          halt,
  input logic [15:0]   sr_out,
  input logic [AW-1:0] sp_out,
  input logic [AW-1:0] pc_out
);
  p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy && !fault_in |=> mem_req && $stable(mem_addr) && $stable(mem_we)
      && $stable(mem_size) && $stable(mem_wdata));

  p_even_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_addr[0]);

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_req && !busy);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> done);

  p_err_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> $stable(sr_out) && $stable(sp_out) && $stable(pc_out));

  p_out_only_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sr_out) && $stable(sp_out) && $stable(pc_out));
endmodule

bind exc_frame_seq exc_frame_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_in(fault_in),
  .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
  .busy(busy), .done(done), .fmt_err(fmt_err), .halt(halt),
  .sr_out(sr_out), .sp_out(sp_out), .pc_out(pc_out)
);

// File: tb/tb_exc_frame_seq.sv
module tb_exc_frame_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, exc_req, rte_req, exc_hw, exc_trap, fault_in;
  logic [1:0]  exc_kind;
  logic [2:0]  exc_ipl;
  logic [7:0]  exc_vec;
  logic [15:0] sr_in;
  logic [31:0] sp_in, pc_in, fault_addr, vbr;
  logic        mem_req, mem_we, mem_size, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, fmt_err, halt;
  logic [15:0] sr_out;
  logic [31:0] sp_out, pc_out;

  exc_frame_seq dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .rte_req(rte_req),
    .exc_kind(exc_kind), .exc_hw(exc_hw), .exc_ipl(exc_ipl), .exc_trap(exc_trap),
    .exc_vec(exc_vec), .sr_in(sr_in), .sp_in(sp_in), .pc_in(pc_in),
    .fault_addr(fault_addr), .vbr(vbr), .fault_in(fault_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .busy(busy), .done(done), .fmt_err(fmt_err), .halt(halt),
    .sr_out(sr_out), .sp_out(sp_out), .pc_out(pc_out)
  );

  int nchk = 0;
  int nfail = 0;
  logic [7:0] mem [0:4095];

  function automatic logic [31:0] rd32(input logic [31:0] a);
    logic [11:0] b = a[11:0];
    return {mem[b], mem[b + 12'd1], mem[b + 12'd2], mem[b + 12'd3]};
  endfunction

  function automatic logic [15:0] rd16(input logic [31:0] a);
    logic [11:0] b = a[11:0];
    return {mem[b], mem[b + 12'd1]};
  endfunction

  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    logic [11:0] b = a[11:0];
    mem[b] = d[31:24]; mem[b + 12'd1] = d[23:16];
    mem[b + 12'd2] = d[15:8]; mem[b + 12'd3] = d[7:0];
  endtask

  task automatic wr16(input logic [31:0] a, input logic [15:0] d);
    logic [11:0] b = a[11:0];
    mem[b] = d[15:8]; mem[b + 12'd1] = d[7:0];
  endtask

  function automatic logic [31:0] vec_pc(input logic [7:0] v);
    return 32'h0004_0000 + 32'(v) * 32'd16;
  endfunction

  always @(negedge clk) begin
    mem_rdy = 1'b0;
    if (mem_req && ($urandom % 4) != 0) begin
      mem_rdy = 1'b1;
      if (mem_we) begin
        if (mem_size) wr32(mem_addr, mem_wdata);
        else wr16(mem_addr, mem_wdata[15:0]);
      end else begin
        mem_rdata = mem_size ? rd32(mem_addr) : {16'h0, rd16(mem_addr)};
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output logic err);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 3000);
    chk("R12 done reached", 32'(done), 32'd1);
    err = fmt_err;
  endtask

  task automatic go_exc(input logic [1:0] kind, input logic hw, input logic [2:0] ipl,
                        input logic trap, input logic [7:0] v, input logic [15:0] sr,
                        input logic [31:0] sp, input logic [31:0] pc, input logic [31:0] fa,
                        input logic both);
    @(negedge clk);
    exc_kind = kind; exc_hw = hw; exc_ipl = ipl; exc_trap = trap; exc_vec = v;
    sr_in = sr; sp_in = sp; pc_in = pc; fault_addr = fa; vbr = 32'h0;
    exc_req = 1'b1; rte_req = both;
    @(negedge clk);
    exc_req = 1'b0; rte_req = 1'b0;
  endtask

  task automatic do_exc(input logic [1:0] kind, input logic hw, input logic [2:0] ipl,
                        input logic trap, input logic [7:0] v, input logic [15:0] sr,
                        input logic [31:0] sp, input logic [31:0] pc, input logic [31:0] fa,
                        input logic roundtrip);
    logic [31:0] spa, ret, f, fsp;
    logic [15:0] srx;
    logic [3:0]  fm;
    int          ext;
    logic        nest, err;
    spa = sp & ~32'd1;
    ret = (trap && !hw) ? pc + 32'd2 : pc;
    srx = (sr | 16'h2000) & ~16'h8000;
    if (hw) srx[10:8] = ipl;
    nest = hw && sr[12];
    if (hw) begin fm = 4'd0; ext = 0; end
    else case (kind)
      2'd0: begin fm = 4'd0; ext = 0; end
      2'd1: begin fm = 4'd2; ext = 1; end
      2'd2: begin fm = 4'd4; ext = 2; end
      default: begin fm = 4'd7; ext = 13; end
    endcase
    go_exc(kind, hw, ipl, trap, v, sr, sp, pc, fa, 1'b0);
    chk("R12 busy after accept", 32'(busy), 32'd1);
    wait_done(err);
    f = spa - 32'd8 - 32'(ext * 4);
    chk("R3 old sr word", 32'(rd16(f)), 32'(sr));
    chk("R5 return address", rd32(f + 32'd2), ret);
    chk("R3 format word", 32'(rd16(f + 32'd6)), 32'({fm, 12'h0}) | (32'(v) << 2));
    if (ext > 0) chk("R4 fault address long", rd32(f + 32'd8), fa);
    if (fm == 4'd4) chk("R4 format 4 pc long", rd32(f + 32'd12), pc);
    if (fm == 4'd7) begin
      chk("R4 format 7 zero fill low", rd32(f + 32'd12), 32'd0);
      chk("R4 format 7 zero fill top", rd32(f + 32'd56), 32'd0);
    end
    if (nest) begin
      fsp = f - 32'd8;
      chk("R6 throwaway sr", 32'(rd16(fsp)), 32'(srx));
      chk("R6 throwaway format word", 32'(rd16(fsp + 32'd6)), 32'h1000 | (32'(v) << 2));
      chk("R6 throwaway return", rd32(fsp + 32'd2), ret);
      chk("R6 final sr master clear", 32'(sr_out), 32'(srx & ~16'h1000));
    end else begin
      fsp = f;
      chk("R1 final sr", 32'(sr_out), 32'(srx));
    end
    chk("R7 sp_out", sp_out, fsp);
    chk("R7 handler pc", pc_out, vec_pc(v));
    chk("R2 frame below aligned sp", 32'(fsp[0]), 32'd0);
    if (roundtrip) begin
      @(negedge clk);
      sp_in = sp_out; rte_req = 1'b1;
      @(negedge clk);
      rte_req = 1'b0;
      wait_done(err);
      chk("R8 return sp", sp_out, spa);
      chk("R8 return sr", 32'(sr_out), 32'(sr));
      chk("R8 return pc", pc_out, ret);
      chk("R9 no error on known format", 32'(err), 32'd0);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic err;
    logic [31:0] sp_keep, pc_keep;
    logic [15:0] sr_keep;
    void'($urandom(32'd7781));
    exc_req = 0; rte_req = 0; exc_kind = 0; exc_hw = 0; exc_ipl = 0; exc_trap = 0;
    exc_vec = 0; sr_in = 0; sp_in = 0; pc_in = 0; fault_addr = 0; vbr = 0; fault_in = 0;
    mem_rdy = 0; mem_rdata = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'hA5;
    for (int v = 0; v < 256; v++) wr32(32'(v) * 32'd4, vec_pc(8'(v)));
    do_reset();

    chk("R12 reset busy", 32'(busy), 32'd0);
    chk("R12 reset done", 32'(done), 32'd0);
    chk("R11 reset mem_req", 32'(mem_req), 32'd0);
    chk("R10 reset halt", 32'(halt), 32'd0);

    // directed kinds, trap, odd stack pointer
    do_exc(2'd0, 1'b0, 3'd0, 1'b0, 8'd5, 16'h8015, 32'h0E81, 32'h0000_1000, 32'h0, 1'b1);
    do_exc(2'd1, 1'b0, 3'd0, 1'b1, 8'd32, 16'h0700, 32'h0E40, 32'h0000_2000, 32'hDEAD_BEEF, 1'b1);
    do_exc(2'd2, 1'b0, 3'd0, 1'b0, 8'd11, 16'hA000, 32'h0E20, 32'h0000_3000, 32'h1234_5678, 1'b1);
    do_exc(2'd3, 1'b0, 3'd0, 1'b0, 8'd2, 16'h0004, 32'h0EC3, 32'h0000_4000, 32'hCAFE_0001, 1'b1);
    // hardware interrupt, with and without master bit
    do_exc(2'd3, 1'b1, 3'd5, 1'b1, 8'd29, 16'h8200, 32'h0E00, 32'h0000_5000, 32'h1, 1'b1);
    do_exc(2'd0, 1'b1, 3'd7, 1'b0, 8'd31, 16'h9300, 32'h0E11, 32'h0000_6000, 32'h2, 1'b1);

    // R12: exc_req wins over rte_req; rte during busy ignored
    go_exc(2'd0, 1'b0, 3'd0, 1'b0, 8'd9, 16'h0000, 32'h0E00, 32'h7000, 32'h0, 1'b1);
    @(negedge clk); rte_req = 1'b1; @(negedge clk); rte_req = 1'b0;
    wait_done(err);
    chk("R12 exc priority handler pc", pc_out, vec_pc(8'd9));
    repeat (4) @(negedge clk);
    chk("R12 request while busy ignored", 32'(busy), 32'd0);

    // R8: handcrafted format 3 frame
    wr16(32'h0A00, 16'h2704); wr32(32'h0A02, 32'h0000_ABCD); wr16(32'h0A06, 16'h3010);
    @(negedge clk); sp_in = 32'h0A00; rte_req = 1'b1; @(negedge clk); rte_req = 1'b0;
    wait_done(err);
    chk("R8 format 3 skip", sp_out, 32'h0A0C);
    chk("R8 format 3 sr", 32'(sr_out), 32'h2704);
    chk("R8 format 3 pc", pc_out, 32'h0000_ABCD);

    // R9: unknown format
    sp_keep = sp_out; sr_keep = sr_out; pc_keep = pc_out;
    wr16(32'h0B00, 16'h2100); wr32(32'h0B02, 32'h0000_1111); wr16(32'h0B06, 16'h5000);
    @(negedge clk); sp_in = 32'h0B00; rte_req = 1'b1; @(negedge clk); rte_req = 1'b0;
    wait_done(err);
    chk("R9 fmt_err pulse", 32'(err), 32'd1);
    chk("R9 sp unchanged", sp_out, sp_keep);
    chk("R9 sr unchanged", 32'(sr_out), 32'(sr_keep));
    chk("R9 pc unchanged", pc_out, pc_keep);

    // R10: fault during format 2 build has no effect
    go_exc(2'd1, 1'b0, 3'd0, 1'b0, 8'd3, 16'h0, 32'h0E00, 32'h8000, 32'h55, 1'b0);
    fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
    wait_done(err);
    chk("R10 no halt outside format 7", 32'(halt), 32'd0);
    chk("R10 format 2 completes", pc_out, vec_pc(8'd3));

    // R10: fault during format 7 build halts
    go_exc(2'd3, 1'b0, 3'd0, 1'b0, 8'd2, 16'h0, 32'h0E00, 32'h9000, 32'h66, 1'b0);
    @(negedge clk);
    fault_in = 1'b1; @(negedge clk); fault_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 halt set", 32'(halt), 32'd1);
    chk("R10 busy dropped", 32'(busy), 32'd0);
    chk("R10 memory idle", 32'(mem_req), 32'd0);
    do_reset();
    chk("R10 halt cleared by reset", 32'(halt), 32'd0);

    // random entries with round trip
    for (int i = 0; i < 60; i++) begin
      logic hw_r;
      hw_r = ($urandom % 3) == 0;
      do_exc(2'($urandom), hw_r, 3'($urandom), 1'($urandom), 8'($urandom), 16'($urandom),
             32'h0D00 + 32'($urandom % 512), $urandom, $urandom, 1'b1);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule